// File: doc/BRIEF.md
# Board Housekeeping Register File

This block is a small byte-addressed register file that sits on a simple local-bus port and gathers the housekeeping controls of a board. Software reads a status byte made from board-type strapping and switch levels, a flash control byte, an interrupt mask byte, a fixed revision byte and a pair of 32-bit test words. Each write takes one clock cycle on a strobe. Reads come from a combinational multiplexer on the current address.

Three outputs leave the block. The first is a hard-reset request, raised only when software writes one exact three-bit key into the control byte. The second is a set of interrupt lines, each gated by its own mask bit. The third is a pair of write-protect lines. Flash protection merges a read-only hardware switch, a software bit that reset sets, and a master switch. The master switch protects every nonvolatile device no matter how the software bits are set. The second test word always returns the bitwise inverse of the first, so software can check both data-bus polarities.

Top module: `brd_ctl_regs`

## Requirements
- R1: A write to the control byte (address 0x01) with wdata[7:5] = 3'b101 raises `hard_rst_req` from the next cycle on, and it stays high until the synchronous reset. A write with any other value in wdata[7:5] leaves `hard_rst_req` low.
- R2: The control byte (address 0x01) always reads as 0x00.
- R3: Synchronous reset sets the software flash-protect bit (address 0x02, bit 2), so `flash_wp` is high after reset.
- R4: The flash byte (address 0x02) reads bit0 = flash ready input, bit1 = hardware protect switch, bit2 = software protect bit. Bits 0 and 1 ignore writes. `flash_wp` is low only when the hardware switch, the software bit and the master switch are all clear.
- R5: When the master protect switch is on, `nv_wp` is high and `flash_wp` is high, whatever the software bit holds.
- R6: Mask byte (address 0x03): a set bit i blocks `irq_src[i]` from `irq_out[i]`, and a clear bit passes it through. All mask bits are set by reset.
- R7: Test word 1 (address 0x08) is a 32-bit read/write register that resets to 0. Test word 2 (address 0x0C) reads as its bitwise complement and ignores writes.
- R8: The revision byte (address 0x04) reads the REV parameter (default 0x01) and ignores writes.
- R9: The status byte (address 0x00) reads bits[1:0] = board type (00 VME single-board computer, 01 processor mezzanine module, 10 and 11 reserved), bit2 = safe-start switch, bit3 = fast-clock switch, bit4 = master protect switch. All other bits read zero.
- R10: Unmapped addresses read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | 6 | Byte address |
| wdata | input | 32 | Write data (bytes use bits 7:0) |
| rdata | output | 32 | Combinational read data |
| brd_kind | input | 2 | Board-type strapping |
| safe_start_sw | input | 1 | Safe-start switch level |
| fast_clk_sw | input | 1 | Fast-clock switch level |
| master_wp_sw | input | 1 | Master write-protect switch |
| flash_hw_wp_sw | input | 1 | Hardware flash protect switch |
| flash_rdy | input | 1 | Flash ready level |
| irq_src | input | NIRQ | Interrupt sources |
| irq_out | output | NIRQ | Masked interrupt lines |
| flash_wp | output | 1 | Flash write protect |
| nv_wp | output | 1 | Protect for all nonvolatile devices |
| hard_rst_req | output | 1 | Hard-reset request |

## Verification
A corrupted software protect bit appears on `flash_wp` in the cycle after the write, and a read of address 0x02 shows it at once. A wrong key decode shows on `hard_rst_req` one cycle after the control write, either as a missing pulse or as one the key did not call for. A bad mask or test-word state shows on `irq_out` or `rdata` in the very next cycle, because both are combinational from the registers. For that reason every check samples one cycle after the write that caused it.

// File: rtl/brd_pkg.sv
package brd_pkg;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam logic [ADDR_W-1:0] A_STAT  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CTL   = 6'h01;
    localparam logic [ADDR_W-1:0] A_FLASH = 6'h02;
    localparam logic [ADDR_W-1:0] A_MASK  = 6'h03;
    localparam logic [ADDR_W-1:0] A_REV   = 6'h04;
    localparam logic [ADDR_W-1:0] A_TST1  = 6'h08;
    localparam logic [ADDR_W-1:0] A_TST2  = 6'h0C;
    localparam logic [2:0] RST_KEY = 3'b101;
endpackage

// File: rtl/brd_rst_decode.sv
module brd_rst_decode (
    input  logic       hit,
    input  logic [2:0] key,
    output logic       fire
);
    assign fire = hit && (key == brd_pkg::RST_KEY);
endmodule

// File: rtl/brd_wp_merge.sv
module brd_wp_merge (
    input  logic master_sw,
    input  logic hw_sw,
    input  logic sw_bit,
    output logic flash_wp,
    output logic nv_wp
);
    assign nv_wp    = master_sw;
    assign flash_wp = master_sw | hw_sw | sw_bit;
endmodule

// File: rtl/brd_irq_mask.sv
module brd_irq_mask #(
    parameter int NIRQ = 4
) (
    input  logic [NIRQ-1:0] src,
    input  logic [NIRQ-1:0] mask,
    output logic [NIRQ-1:0] gated
);
    for (genvar i = 0; i < NIRQ; i++) begin : g_gate
        assign gated[i] = src[i] & ~mask[i];
    end
endmodule

// File: rtl/brd_ctl_regs.sv
module brd_ctl_regs
    import brd_pkg::*;
#(
    parameter int          NIRQ = 4,
    parameter logic [7:0]  REV  = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    input  logic [1:0]           brd_kind,
    input  logic                 safe_start_sw,
    input  logic                 fast_clk_sw,
    input  logic                 master_wp_sw,
    input  logic                 flash_hw_wp_sw,
    input  logic                 flash_rdy,
    input  logic [NIRQ-1:0]      irq_src,
    output logic [NIRQ-1:0]      irq_out,
    output logic                 flash_wp,
    output logic                 nv_wp,
    output logic                 hard_rst_req
);
    typedef struct packed {
        logic              rst_req;
        logic              sw_wp;
        logic [NIRQ-1:0]   mask;
        logic [DATA_W-1:0] tst1;
    } regs_t;

    localparam regs_t RESET_ST = '{rst_req: 1'b0, sw_wp: 1'b1,
                                   mask: {NIRQ{1'b1}}, tst1: '0};

    regs_t st_q, st_d;
    logic  key_fire;

    brd_rst_decode u_key (
        .hit  (wr_en && addr == A_CTL),
        .key  (wdata[7:5]),
        .fire (key_fire)
    );

    always_comb begin
        st_d = st_q;
        if (key_fire) st_d.rst_req = 1'b1;
        if (wr_en) begin
            case (addr)
                A_FLASH: st_d.sw_wp = wdata[2];
                A_MASK:  st_d.mask  = wdata[NIRQ-1:0];
                A_TST1:  st_d.tst1  = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RESET_ST;
        else     st_q <= st_d;
    end

    always_comb begin
        case (addr)
            A_STAT:  rdata = {27'b0, master_wp_sw, fast_clk_sw, safe_start_sw, brd_kind};
            A_FLASH: rdata = {29'b0, st_q.sw_wp, flash_hw_wp_sw, flash_rdy};
            A_MASK:  rdata = DATA_W'(st_q.mask);
            A_REV:   rdata = {24'b0, REV};
            A_TST1:  rdata = st_q.tst1;
            A_TST2:  rdata = ~st_q.tst1;
            default: rdata = '0;
        endcase
    end

    brd_wp_merge u_wp (
        .master_sw (master_wp_sw),
        .hw_sw     (flash_hw_wp_sw),
        .sw_bit    (st_q.sw_wp),
        .flash_wp  (flash_wp),
        .nv_wp     (nv_wp)
    );

    brd_irq_mask #(.NIRQ(NIRQ)) u_irq (
        .src   (irq_src),
        .mask  (st_q.mask),
        .gated (irq_out)
    );

    assign hard_rst_req = st_q.rst_req;
endmodule

// File: rtl/brd_ctl_regs_chk.sv
module brd_ctl_regs_chk
    import brd_pkg::*;
#(
    parameter int         NIRQ = 4,
    parameter logic [7:0] REV  = 8'h01
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              master_wp_sw,
    input logic [NIRQ-1:0]   irq_src,
    input logic [NIRQ-1:0]   irq_out,
    input logic              flash_wp,
    input logic              nv_wp,
    input logic              hard_rst_req
);
    p_key_fires_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_CTL && wdata[7:5] == 3'b101) |=> hard_rst_req);

    p_no_false_reset_r1: assert property (@(posedge clk) disable iff (rst)
        (!hard_rst_req && !(wr_en && addr == A_CTL && wdata[7:5] == 3'b101))
        |=> !hard_rst_req);

    p_req_sticky_r1: assert property (@(posedge clk) disable iff (rst)
        hard_rst_req |=> hard_rst_req);

    p_ctl_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTL) |-> (rdata == '0));

    p_master_protects_r5: assert property (@(posedge clk) disable iff (rst)
        master_wp_sw |-> (flash_wp && nv_wp));

    p_irq_needs_src_r6: assert property (@(posedge clk) disable iff (rst)
        ((irq_out & ~irq_src) == '0));

    p_tst2_inverse_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_TST1) ##1 (addr == A_TST2 && !wr_en)
        |-> (rdata == ~$past(wdata)));

    p_rev_fixed_r8: assert property (@(posedge clk) disable iff (rst)
        (addr == A_REV) |-> (rdata == {24'b0, REV}));
endmodule

bind brd_ctl_regs brd_ctl_regs_chk #(.NIRQ(NIRQ), .REV(REV)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .master_wp_sw(master_wp_sw), .irq_src(irq_src),
    .irq_out(irq_out), .flash_wp(flash_wp), .nv_wp(nv_wp),
    .hard_rst_req(hard_rst_req)
);

// File: tb/tb_brd_ctl_regs.sv
`timescale 1ns/1ps
module tb_brd_ctl_regs;
    localparam int NIRQ = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  brd_kind = 2'b01;
    logic        safe_start_sw = 1'b1;
    logic        fast_clk_sw = 1'b0;
    logic        master_wp_sw = 1'b0;
    logic        flash_hw_wp_sw = 1'b0;
    logic        flash_rdy = 1'b1;
    logic [NIRQ-1:0] irq_src = '0;
    logic [NIRQ-1:0] irq_out;
    logic        flash_wp, nv_wp, hard_rst_req;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        logic [5:0]  a;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    always #5 clk = ~clk;

    brd_ctl_regs dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .brd_kind(brd_kind), .safe_start_sw(safe_start_sw),
        .fast_clk_sw(fast_clk_sw), .master_wp_sw(master_wp_sw),
        .flash_hw_wp_sw(flash_hw_wp_sw), .flash_rdy(flash_rdy),
        .irq_src(irq_src), .irq_out(irq_out), .flash_wp(flash_wp),
        .nv_wp(nv_wp), .hard_rst_req(hard_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected reads and compares one step after the edge
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            rd_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, rdata, it.exp);
        end
    end

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        addr = a;
        it.a = a; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state
        rd(6'h00, 32'h05, "R9 status after reset");
        rd(6'h02, 32'h05, "R3 flash byte after reset");
        chk("R3 flash_wp after reset", 32'(flash_wp), 32'd1);
        chk("R1 no request after reset", 32'(hard_rst_req), 32'd0);
        rd(6'h03, 32'h0F, "R6 mask after reset");
        rd(6'h04, 32'h01, "R8 revision");
        rd(6'h08, 32'h0, "R7 test1 after reset");
        rd(6'h0C, 32'hFFFF_FFFF, "R7 test2 after reset");
        rd(6'h01, 32'h0, "R2 control reads zero");

        // Interrupt masking
        @(negedge clk); irq_src = 4'b1111;
        @(negedge clk); chk("R6 all masked", 32'(irq_out), 32'h0);
        wr(6'h03, 32'h05);
        chk("R6 partial mask", 32'(irq_out), 32'hA);
        rd(6'h03, 32'h05, "R6 mask readback");
        @(negedge clk); irq_src = 4'b0010;
        @(negedge clk); chk("R6 single source", 32'(irq_out), 32'h2);

        // Flash protection merge
        wr(6'h02, 32'h00);
        chk("R4 unprotected", 32'(flash_wp), 32'd0);
        wr(6'h02, 32'h03);
        rd(6'h02, 32'h01, "R4 read-only bits ignore writes");
        chk("R4 still unprotected", 32'(flash_wp), 32'd0);
        @(negedge clk); flash_hw_wp_sw = 1'b1;
        @(negedge clk); chk("R4 hw switch protects", 32'(flash_wp), 32'd1);
        rd(6'h02, 32'h03, "R4 hw switch visible");
        @(negedge clk); flash_hw_wp_sw = 1'b0; master_wp_sw = 1'b1;
        @(negedge clk);
        chk("R5 master nv_wp", 32'(nv_wp), 32'd1);
        chk("R5 master flash_wp", 32'(flash_wp), 32'd1);
        rd(6'h00, 32'h15, "R9 master switch bit");
        @(negedge clk); master_wp_sw = 1'b0; brd_kind = 2'b00; fast_clk_sw = 1'b1;
        @(negedge clk); chk("R5 master off", 32'(nv_wp), 32'd0);
        rd(6'h00, 32'h0C, "R9 board type 00 and fast clock");

        // Test words
        wr(6'h08, 32'hA5C3_0F96);
        rd(6'h08, 32'hA5C3_0F96, "R7 test1 readback");
        rd(6'h0C, 32'h5A3C_F069, "R7 test2 complement");
        wr(6'h0C, 32'h1234_5678);
        rd(6'h08, 32'hA5C3_0F96, "R7 test2 write ignored");
        wr(6'h04, 32'hFF);
        rd(6'h04, 32'h01, "R8 revision write ignored");

        // Unmapped
        wr(6'h05, 32'hFFFF_FFFF);
        rd(6'h05, 32'h0, "R10 unmapped reads zero");
        rd(6'h03, 32'h05, "R10 mask untouched");
        rd(6'h08, 32'hA5C3_0F96, "R10 test1 untouched");

        // Reset key
        wr(6'h01, 32'hC0);
        chk("R1 pattern 110 ignored", 32'(hard_rst_req), 32'd0);
        wr(6'h01, 32'h20);
        chk("R1 pattern 001 ignored", 32'(hard_rst_req), 32'd0);
        wr(6'h01, 32'hE0);
        chk("R1 pattern 111 ignored", 32'(hard_rst_req), 32'd0);
        wr(6'h03, 32'hA0);
        chk("R1 key at other address ignored", 32'(hard_rst_req), 32'd0);
        wr(6'h01, 32'hBF);
        chk("R1 key fires", 32'(hard_rst_req), 32'd1);
        rd(6'h01, 32'h0, "R2 control reads zero after key");
        chk("R1 request held", 32'(hard_rst_req), 32'd1);

        // Reset again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 request cleared by reset", 32'(hard_rst_req), 32'd0);
        chk("R3 flash_wp set again", 32'(flash_wp), 32'd1);
        rd(6'h03, 32'h0F, "R6 mask set again");
        rd(6'h08, 32'h0, "R7 test1 cleared");
        @(negedge clk);
        finish_run();
    end
endmodule